// File: doc/BRIEF.md
# Privilege-Filtered Performance Event Counter Bank

A bank of generic event counters for performance monitoring. Each counter has a configuration register and a CNT_W-bit count register, and it watches one line of a 256-entry event vector. When that line is high, the counter adds one. It does so only in a cycle where the global count enable is high, the shared freeze flag is clear, and the bit of the counter's privilege mask picked by the current privilege level is set.

When a counter wraps from all ones to zero, its bit in a shared overflow status register is set. If the counter's interrupt-enable bit is set, the wrap also sets the freeze flag, which stops every counter in the bank. In that case a one-cycle interrupt pulse is raised, but only if the counter's status bit was clear before the wrap. Clearing freeze alone therefore never produces another interrupt for an overflow that has already been reported. A counter whose external-notify bit is set also gives a one-cycle pulse on its own notify line when it wraps.

Software reaches all state through a single-cycle register port. Writes are registered and reads are combinational. The address map is:
- address 0: control, with bit 0 holding the freeze flag
- address 1: overflow status, with bit i belonging to counter i
- address 2+2i: configuration register of counter i
- address 3+2i: count register of counter i

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every register reads zero: control, status, all configuration registers and all count registers. irq_o and every notify_o bit are low.
- R2: The configuration register stores these fields, and reads return bit 7 and bits 63:16 as zero:
  - the privilege mask in bits 3:0
  - the notify enable in bit 4
  - the interrupt enable in bit 5
  - a privileged-monitor flag in bit 6 (stored only)
  - the event select in bits 15:8
- R3: A count register stores bits CNT_W-1:0 of the write data. Higher write bits are dropped, and reads return zero above bit CNT_W-1.
- R4: A counter adds exactly one per clock edge at which all four of these hold:
  - the selected event line is high
  - cnt_en_i is high
  - mask bit priv_i of the counter's privilege mask is 1
  - freeze is clear
  At any other edge the count is unchanged.
- R5: While the freeze flag (control bit 0) is 1, no counter changes except by a register write. Software sets and clears the flag by writing control bit 0.
- R6: An increment from all ones leaves the count at zero and sets the counter's status bit.
- R7: On a wrap with the interrupt enable set, the freeze flag is set. irq_o is high for the one cycle after the wrapping edge if the counter's status bit was clear before it. With the interrupt enable clear, irq_o stays low and freeze is unchanged.
- R8: After an overflow has been reported, no further interrupt occurs while its status bit stays set. This holds when freeze is cleared, and it holds when the same counter wraps again. Once the status bit has been cleared, the next wrap interrupts again.
- R9: On a wrap with the notify enable set, notify_o[i] is high for the one cycle after the wrapping edge.
- R10: Writing the status register clears the bits written as 1 and leaves the bits written as 0. A wrap in the same cycle as the write keeps its bit set.
- R11: A write to a count register in the same cycle as a qualifying event stores the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Global count enable |
| priv_i | input | 2 | Current privilege level |
| event_i | input | NUM_EVT | Event lines, one increment per high cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| irq_o | output | 1 | Overflow interrupt pulse |
| notify_o | output | NUM_CTR | Per-counter overflow notification pulse |

## Verification
The hardest case to reach is the no-repeat rule. It needs one overflow already reported, then freeze cleared while the status bit stays set, and then a second wrap of the same counter. The bench gets there by preloading the count register with all ones, so one event cycle causes the wrap. It then samples irq_o on the cycle after each wrap, before and after a write-one-to-clear of the status bit. The status clear that collides with a wrap is reached by issuing the status write and the final event in the same cycle.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int EVT_SPACE = 256;
  localparam int ADDR_CTL  = 0;
  localparam int ADDR_STS  = 1;
  localparam int ADDR_BASE = 2;

  typedef struct packed {
    logic [7:0] evsel;
    logic       pm;
    logic       oi;
    logic       ev;
    logic [3:0] plm;
  } ctr_cfg_t;

  function automatic ctr_cfg_t cfg_from_word(input logic [63:0] w);
    ctr_cfg_t c;
    c.plm   = w[3:0];
    c.ev    = w[4];
    c.oi    = w[5];
    c.pm    = w[6];
    c.evsel = w[15:8];
    return c;
  endfunction

  function automatic logic [63:0] cfg_to_word(input ctr_cfg_t c);
    return {48'h0, c.evsel, 1'b0, c.pm, c.oi, c.ev, c.plm};
  endfunction
endpackage

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import perf_ctr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 cnt_we_i,
  input  logic [63:0]          wdata_i,
  input  logic                 count_ok_i,
  input  logic [1:0]           priv_i,
  input  logic [EVT_SPACE-1:0] evt_i,
  output ctr_cfg_t             cfg_o,
  output logic [CNT_W-1:0]     count_o,
  output logic                 wrap_o
);
  ctr_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc    = count_ok_i & cfg_q.plm[priv_i] & evt_i[cfg_q.evsel];
  // software write wins, so the carry is dropped with the increment
  assign wrap_o = inc & ~cnt_we_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_from_word(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i[CNT_W-1:0];
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cfg_o   = cfg_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/perf_ctr_ovf_ctl.sv
module perf_ctr_ovf_ctl #(
  parameter int NUM_CTR = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CTR-1:0] wrap_i,
  input  logic [NUM_CTR-1:0] oi_i,
  input  logic [NUM_CTR-1:0] ev_i,
  input  logic               ctl_we_i,
  input  logic               ctl_freeze_i,
  input  logic               sts_we_i,
  input  logic [NUM_CTR-1:0] sts_clr_i,
  output logic               freeze_o,
  output logic [NUM_CTR-1:0] ovf_o,
  output logic               irq_o,
  output logic [NUM_CTR-1:0] notify_o
);
  logic               freeze_q, freeze_d;
  logic [NUM_CTR-1:0] ovf_q, ovf_d, irq_hit;
  logic               irq_q;
  logic [NUM_CTR-1:0] notify_q;

  // an interrupting wrap overrides a same-cycle software clear of freeze
  always_comb begin
    freeze_d = freeze_q;
    if (|(wrap_i & oi_i)) freeze_d = 1'b1;
    else if (ctl_we_i)    freeze_d = ctl_freeze_i;
  end

  always_comb begin
    ovf_d = ovf_q;
    if (sts_we_i) ovf_d = ovf_q & ~sts_clr_i;
    ovf_d = ovf_d | wrap_i;
  end

  // edge rule: only a wrap on a not-yet-reported counter interrupts
  assign irq_hit = wrap_i & oi_i & ~ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
      ovf_q    <= '0;
      irq_q    <= 1'b0;
      notify_q <= '0;
    end else begin
      freeze_q <= freeze_d;
      ovf_q    <= ovf_d;
      irq_q    <= |irq_hit;
      notify_q <= wrap_i & ev_i;
    end
  end

  assign freeze_o = freeze_q;
  assign ovf_o    = ovf_q;
  assign irq_o    = irq_q;
  assign notify_o = notify_q;
endmodule

// File: rtl/perf_ctr_rdmux.sv
module perf_ctr_rdmux
  import perf_ctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          freeze_i,
  input  logic [NUM_CTR-1:0]            ovf_i,
  input  ctr_cfg_t [NUM_CTR-1:0]        cfg_i,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_i,
  output logic [63:0]                   rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) == ADDR_CTL) begin
      rdata_o[0] = freeze_i;
    end else if (int'(addr_i) == ADDR_STS) begin
      rdata_o[NUM_CTR-1:0] = ovf_i;
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (int'(addr_i) == ADDR_BASE + 2*i)     rdata_o = cfg_to_word(cfg_i[i]);
        if (int'(addr_i) == ADDR_BASE + 2*i + 1) rdata_o = 64'(cnt_i[i]);
      end
    end
  end
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = 16,
  parameter int NUM_EVT = 256,
  parameter int ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic [1:0]         priv_i,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  output logic               irq_o,
  output logic [NUM_CTR-1:0] notify_o
);
  logic [EVT_SPACE-1:0]          evt_ext;
  ctr_cfg_t [NUM_CTR-1:0]        cfg_q;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CTR-1:0]            wrap, oi_v, ev_v, cfg_we, cnt_we, ovf_q;
  logic                          freeze_q, ctl_we, sts_we, count_ok;

  // unused select codes see a constant zero
  always_comb begin
    evt_ext = '0;
    evt_ext[NUM_EVT-1:0] = event_i;
  end

  assign ctl_we   = reg_we_i && (int'(reg_addr_i) == ADDR_CTL);
  assign sts_we   = reg_we_i && (int'(reg_addr_i) == ADDR_STS);
  assign count_ok = cnt_en_i & ~freeze_q;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign cfg_we[i] = reg_we_i && (int'(reg_addr_i) == ADDR_BASE + 2*i);
    assign cnt_we[i] = reg_we_i && (int'(reg_addr_i) == ADDR_BASE + 2*i + 1);
    assign oi_v[i]   = cfg_q[i].oi;
    assign ev_v[i]   = cfg_q[i].ev;

    perf_ctr_unit #(.CNT_W(CNT_W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we[i]),
      .cnt_we_i   (cnt_we[i]),
      .wdata_i    (reg_wdata_i),
      .count_ok_i (count_ok),
      .priv_i     (priv_i),
      .evt_i      (evt_ext),
      .cfg_o      (cfg_q[i]),
      .count_o    (cnt_q[i]),
      .wrap_o     (wrap[i])
    );
  end

  perf_ctr_ovf_ctl #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wrap_i       (wrap),
    .oi_i         (oi_v),
    .ev_i         (ev_v),
    .ctl_we_i     (ctl_we),
    .ctl_freeze_i (reg_wdata_i[0]),
    .sts_we_i     (sts_we),
    .sts_clr_i    (reg_wdata_i[NUM_CTR-1:0]),
    .freeze_o     (freeze_q),
    .ovf_o        (ovf_q),
    .irq_o        (irq_o),
    .notify_o     (notify_o)
  );

  perf_ctr_rdmux #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .addr_i   (reg_addr_i),
    .freeze_i (freeze_q),
    .ovf_i    (ovf_q),
    .cfg_i    (cfg_q),
    .cnt_i    (cnt_q),
    .rdata_o  (reg_rdata_o)
  );
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          reg_we_i,
  input logic [ADDR_W-1:0]             reg_addr_i,
  input logic [63:0]                   reg_rdata_o,
  input logic                          irq_o,
  input logic [NUM_CTR-1:0]            notify_o,
  input logic                          freeze_q,
  input logic [NUM_CTR-1:0]            ovf_q,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q
);
  logic is_cnt_addr;
  assign is_cnt_addr = reg_addr_i[0] && (int'(reg_addr_i) >= 3)
                       && (int'(reg_addr_i) < 2 + 2*NUM_CTR);

  assert_irq_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> freeze_q);

  assert_irq_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_q != '0));

  assert_freeze_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_q && !reg_we_i) |=> $stable(cnt_q));

  assert_notify_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_o != '0) |-> ((notify_o & ~ovf_q) == '0));

  assert_cnt_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cnt_addr |-> ((reg_rdata_o >> CNT_W) == 64'h0));
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(
  .NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .notify_o    (notify_o),
  .freeze_q    (freeze_q),
  .ovf_q       (ovf_q),
  .cnt_q       (cnt_q)
);

// File: tb/perf_ctr_bank_tb_top.sv
module perf_ctr_bank_tb_top;
  localparam int NUM_CTR = 4;
  localparam int CNT_W   = 16;
  localparam int NUM_EVT = 256;
  localparam int ADDR_W  = 8;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               cnt_en_i = 1'b0;
  logic [1:0]         priv_i = 2'd0;
  logic [NUM_EVT-1:0] event_i = '0;
  logic               reg_we_i = 1'b0;
  logic [ADDR_W-1:0]  reg_addr_i = '0;
  logic [63:0]        reg_wdata_i = '0;
  logic [63:0]        reg_rdata_o;
  logic               irq_o;
  logic [NUM_CTR-1:0] notify_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5ns clk_i = ~clk_i;

  perf_ctr_bank #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) dut_i (
    .clk_i, .rst_ni, .cnt_en_i, .priv_i, .event_i, .reg_we_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o, .notify_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = ADDR_W'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] d);
    reg_addr_i = ADDR_W'(a);
    #1ns;
    d = reg_rdata_o;
  endtask

  task automatic evt(input int sel, input int cycles);
    @(negedge clk_i);
    event_i = '0; event_i[sel] = 1'b1;
    repeat (cycles) @(negedge clk_i);
    event_i = '0;
  endtask

  function automatic logic [63:0] cfg(input logic [7:0] sel, input logic oi,
                                      input logic ev, input logic [3:0] plm);
    return {48'h0, sel, 1'b0, 1'b0, oi, ev, plm};
  endfunction

  task automatic t_reset();
    logic [63:0] d;
    rd(0, d); chk("R1 control", d, 0);
    rd(1, d); chk("R1 status", d, 0);
    rd(2, d); chk("R1 cfg0", d, 0);
    rd(9, d); chk("R1 cnt3", d, 0);
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 notify", 64'(notify_o), 0);
  endtask

  task automatic t_cfg();
    logic [63:0] d;
    wr(4, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4, d); chk("R2 cfg all ones", d, 64'h0000_0000_0000_FF7F);
    wr(4, 64'h1234_5678_0000_A5C3);
    rd(4, d); chk("R2 cfg pattern", d, 64'h0000_0000_0000_A543);
  endtask

  task automatic t_data();
    logic [63:0] d;
    wr(5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(5, d); chk("R3 cnt upper zero", d, 64'h0000_0000_0000_FFFF);
    wr(5, 64'hABCD_0000_0000_1234);
    rd(5, d); chk("R3 cnt low bits", d, 64'h1234);
  endtask

  task automatic t_count();
    logic [63:0] d;
    wr(4, cfg(8'd5, 0, 0, 4'b0101));
    wr(5, 0);
    cnt_en_i = 1'b1;
    priv_i = 2'd0; evt(5, 3);
    rd(5, d); chk("R4 level0 enabled", d, 3);
    priv_i = 2'd1; evt(5, 3);
    rd(5, d); chk("R4 level1 masked", d, 3);
    priv_i = 2'd2; evt(5, 2);
    rd(5, d); chk("R4 level2 enabled", d, 5);
    cnt_en_i = 1'b0; evt(5, 2);
    rd(5, d); chk("R4 global enable low", d, 5);
    cnt_en_i = 1'b1; evt(4, 2);
    rd(5, d); chk("R4 other event", d, 5);
  endtask

  task automatic t_freeze();
    logic [63:0] d;
    wr(0, 1);
    rd(0, d); chk("R5 freeze set", d, 1);
    evt(5, 3);
    rd(5, d); chk("R5 frozen count", d, 5);
    wr(0, 0);
    evt(5, 1);
    rd(5, d); chk("R5 thawed count", d, 6);
  endtask

  task automatic t_priority();
    logic [63:0] d;
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'd5; reg_wdata_i = 64'd100; event_i[5] = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; event_i = '0;
    rd(5, d); chk("R11 write beats increment", d, 100);
  endtask

  task automatic t_wrap_no_oi();
    logic [63:0] d;
    priv_i = 2'd0;
    wr(6, cfg(8'd7, 0, 0, 4'b0001));
    wr(7, 64'hFFFF);
    evt(7, 1);
    chk("R7 no irq without oi", 64'(irq_o), 0);
    chk("R9 no notify without ev", 64'(notify_o), 0);
    rd(7, d); chk("R6 wrapped to zero", d, 0);
    rd(1, d); chk("R6 status bit2", d, 4);
    rd(0, d); chk("R7 freeze unchanged", d, 0);
  endtask

  task automatic t_status();
    logic [63:0] d;
    wr(1, 0);
    rd(1, d); chk("R10 zero write keeps", d, 4);
    wr(7, 64'hFFFF);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'd1; reg_wdata_i = 64'd4; event_i[7] = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; event_i = '0;
    rd(1, d); chk("R10 wrap beats clear", d, 4);
    wr(1, 4);
    rd(1, d); chk("R10 clear", d, 0);
  endtask

  task automatic t_irq();
    logic [63:0] d;
    wr(2, cfg(8'd3, 1, 1, 4'b0001));
    wr(3, 64'hFFFF);
    evt(3, 1);
    chk("R7 irq pulse", 64'(irq_o), 1);
    chk("R9 notify pulse", 64'(notify_o), 1);
    @(negedge clk_i);
    chk("R7 irq one cycle", 64'(irq_o), 0);
    chk("R9 notify one cycle", 64'(notify_o), 0);
    rd(0, d); chk("R7 freeze set", d, 1);
    rd(1, d); chk("R6 status bit0", d, 1);
  endtask

  task automatic t_no_repeat();
    logic [63:0] d;
    wr(0, 0);
    chk("R8 no irq on freeze clear", 64'(irq_o), 0);
    @(negedge clk_i);
    chk("R8 still no irq", 64'(irq_o), 0);
    wr(3, 64'hFFFF);
    evt(3, 1);
    chk("R8 no irq on repeat wrap", 64'(irq_o), 0);
    rd(3, d); chk("R6 second wrap", d, 0);
    rd(0, d); chk("R7 freeze set again", d, 1);
    wr(1, 1);
    wr(0, 0);
    wr(3, 64'hFFFF);
    evt(3, 1);
    chk("R8 irq after status clear", 64'(irq_o), 1);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_cfg();
    t_data();
    t_count();
    t_freeze();
    t_priority();
    t_wrap_no_oi();
    t_status();
    t_irq();
    t_no_repeat();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule